// File: doc/BRIEF.md
# PC Card 16-bit Host Cycle Sequencer

This block sits on the host side of a 16-bit PC Card socket. It takes one access at a time from a simple valid/ready host port and turns it into a timed sequence on the card's active-low control lines. Each request names the kind of access, the direction, an address, the data to write, and two flags: one for a 16-bit I/O access and one for the last DMA transfer. The block returns a one-clock done pulse and, for reads, the assembled read data.

Each card cycle has four phases: address setup, the strobe itself, one wait-check clock that repeats while the card stretches the cycle, and a hold phase. The setup, strobe and hold lengths come from host-programmed counts. Every card status input passes through a two-flop synchronizer before the sequencer uses it. The card's ready line blocks new memory accesses. The write-protect line serves as the DMA request. The 16-bit port flag can split one I/O access into two byte cycles. A separate command issues a card reset pulse of programmable length. The pulse aborts any access in progress and holds off new ones.

Kind encoding used throughout: 0 = common memory, 1 = attribute memory, 2 = I/O space, 3 = DMA.

Top module: `pc16_cycle_seq`

## Requirements
- R1: `reg_n` stays high while idle and for the whole of a kind-0 access. It is low from the first setup clock to the last hold clock of every kind-1, kind-2 and kind-3 access.
- R2: A memory access (kind 0 or 1) drives `oe_n` low when reading and `we_n` low when writing, only during the strobe and wait-check clocks.
- R3: A card cycle lasts max(S,1) setup clocks, max(T,1) strobe clocks, one wait-check clock and max(H,1) hold clocks, where S, T and H are `setup_clks`, `strobe_clks` and `hold_clks`. `rsp_done` is high for exactly the first clock after the last hold clock.
- R4: On each wait-check clock where the synchronized `wait_n` is low, the strobe stays active for one more clock. The cycle moves to hold only on a wait-check clock that sees `wait_n` high.
- R5: A kind 0 or 1 request is not accepted (`req_ready` low) while the synchronized `ready` is low.
- R6: An I/O access (kind 2) drives `iord_n` low when reading and `iowr_n` low when writing, during the strobe and wait-check clocks.
- R7: A DMA access (kind 3) with `req_write`=1 moves data toward the card and strobes `iowr_n`. With `req_last` set, it also drives `we_n` low in the same clocks as terminal count. With `req_write`=0, it strobes `iord_n`, and with `req_last` set it drives `oe_n` low as terminal count.
- R8: A kind-3 request is accepted only while the synchronized `wp_dreq` is high.
- R9: For a kind-2 request with `req_wide`=1, the first cycle uses the address with bit 0 cleared. If the synchronized `iois16_n` is high on that cycle's final wait-check clock, a second full cycle follows at the address with bit 0 set. In that second cycle a write drives `{8'h00, req_wdata[15:8]}` on `card_dout`, and a read fills bits 15:8 of the result from `card_din[7:0]`.
- R10: Read data is taken from `card_din` on the final wait-check clock. Memory and DMA reads, and wide I/O reads with `iois16_n` low, return all 16 bits. A byte I/O read (`req_wide`=0) returns `{8'h00, card_din[7:0]}`. The first byte of a split read fills bits 7:0.
- R11: `reset_cmd` starts a `card_reset` pulse of max(`reset_clks`,1) clocks. It ends any access at once without `rsp_done`, and keeps all strobes high and `req_ready` low until the pulse ends.
- R12: A change on `wait_n`, `ready`, `wp_dreq` or `iois16_n` reaches the sequencer exactly two clocks after it is sampled.
- R13: `card_addr` and `card_dout` stay stable for the whole access. `card_dout_en` is high from the first setup clock to the last hold clock of every access that moves data toward the card.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| setup_clks | input | CW | Address setup length in clocks (0 acts as 1) |
| strobe_clks | input | CW | Minimum strobe length in clocks (0 acts as 1) |
| hold_clks | input | CW | Hold length after the strobe (0 acts as 1) |
| reset_clks | input | RW | Card reset pulse length (0 acts as 1) |
| reset_cmd | input | 1 | Start a card reset pulse |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this clock if valid |
| req_kind | input | 2 | 0 common mem, 1 attribute mem, 2 I/O, 3 DMA |
| req_write | input | 1 | 1 = data toward the card |
| req_wide | input | 1 | I/O only: 16-bit access requested |
| req_last | input | 1 | DMA only: final transfer (terminal count) |
| req_addr | input | AW | Access address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read result, valid with and after `rsp_done` |
| card_reset | output | 1 | Card hard reset, active high |
| card_addr | output | AW | Card address bus |
| card_dout | output | 16 | Data driven to the card |
| card_dout_en | output | 1 | Enables the data bus driver toward the card |
| card_din | input | 16 | Data from the card |
| oe_n | output | 1 | Memory output enable, or DMA terminal count on card-to-host transfers |
| we_n | output | 1 | Memory write strobe, or DMA terminal count on host-to-card transfers |
| iord_n | output | 1 | I/O read strobe |
| iowr_n | output | 1 | I/O write strobe |
| reg_n | output | 1 | Attribute/I/O select, DMA acknowledge |
| wait_n | input | 1 | Card cycle stretch request, active low |
| ready | input | 1 | Card ready for a new memory transfer |
| wp_dreq | input | 1 | Write-protect pin used as the DMA request |
| iois16_n | input | 1 | Card reports a 16-bit I/O port, active low |

## Verification
The assertions assume that the host holds the request fields and the timing counts steady while a request waits and while an access runs. They also assume the card releases `wait_n` within a bounded time, so that a strobe held active always ends. The bench changes `setup_clks`, `strobe_clks`, `hold_clks` and `reset_clks` only while the block is idle. It lifts `req_valid` on the first falling edge after acceptance, and it always raises `wait_n` again after a fixed number of clocks. The card data bus is changed only between the two byte cycles of a split access, never near a capture edge.

// File: rtl/pc16_cycle_seq.sv
module pc16_cycle_seq #(
  parameter int AW = 16,
  parameter int CW = 4,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] setup_clks,
  input  logic [CW-1:0] strobe_clks,
  input  logic [CW-1:0] hold_clks,
  input  logic [RW-1:0] reset_clks,
  input  logic          reset_cmd,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic          req_write,
  input  logic          req_wide,
  input  logic          req_last,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          rsp_done,
  output logic [15:0]   rsp_rdata,
  output logic          card_reset,
  output logic [AW-1:0] card_addr,
  output logic [15:0]   card_dout,
  output logic          card_dout_en,
  input  logic [15:0]   card_din,
  output logic          oe_n,
  output logic          we_n,
  output logic          iord_n,
  output logic          iowr_n,
  output logic          reg_n,
  input  logic          wait_n,
  input  logic          ready,
  input  logic          wp_dreq,
  input  logic          iois16_n
);

  typedef enum logic [2:0] {IDLE, SETUP, STROBE, WAITCK, HOLD} st_t;

  st_t           st;
  logic [3:0]    sy1, sy2;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rcnt;
  logic [1:0]    k;
  logic          wr, wide, last, second, narrow, done_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   wd_q, rd_q;

  function automatic logic [CW-1:0] lim(input logic [CW-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  wire wait_on = ~sy2[0];
  wire rdy_s   = sy2[1];
  wire dreq_s  = sy2[2];
  wire is16_s  = ~sy2[3];

  wire mem  = ~k[1];
  wire io   = (k == 2'd2);
  wire dma  = (k == 2'd3);
  wire busy = (st != IDLE);
  wire act  = (st == STROBE) || (st == WAITCK);

  wire go   = req_kind[1] ? (req_kind[0] ? dreq_s : 1'b1) : rdy_s;
  assign req_ready = !busy && (rcnt == '0) && go;
  wire take = req_valid && req_ready && !reset_cmd;

  assign oe_n   = ~(act & ((mem & ~wr) | (dma & ~wr & last)));
  assign we_n   = ~(act & ((mem &  wr) | (dma &  wr & last)));
  assign iord_n = ~(act & (io | dma) & ~wr);
  assign iowr_n = ~(act & (io | dma) &  wr);
  assign reg_n  = ~(busy & (k != 2'd0));

  assign card_reset   = (rcnt != '0);
  assign card_addr    = addr_q;
  assign card_dout_en = busy & wr;
  assign card_dout    = second ? {8'h00, wd_q[15:8]} : wd_q;
  assign rsp_done     = done_q;
  assign rsp_rdata    = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= 4'b1011;
      sy2 <= 4'b1011;
    end else begin
      sy1 <= {iois16_n, wp_dreq, ready, wait_n};
      sy2 <= sy1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      rcnt   <= '0;
      k      <= 2'd0;
      wr     <= 1'b0;
      wide   <= 1'b0;
      last   <= 1'b0;
      second <= 1'b0;
      narrow <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (rcnt != '0) rcnt <= rcnt - 1'b1;
      if (reset_cmd) begin
        st     <= IDLE;
        second <= 1'b0;
        rcnt   <= (reset_clks == '0) ? RW'(1) : reset_clks;
      end else begin
        case (st)
          IDLE: if (take) begin
            k      <= req_kind;
            wr     <= req_write;
            wide   <= req_wide;
            last   <= req_last;
            wd_q   <= req_wdata;
            second <= 1'b0;
            addr_q <= (req_kind == 2'd2 && req_wide) ? {req_addr[AW-1:1], 1'b0} : req_addr;
            cnt    <= lim(setup_clks);
            st     <= SETUP;
          end
          SETUP: if (cnt == '0) begin
            cnt <= lim(strobe_clks);
            st  <= STROBE;
          end else cnt <= cnt - 1'b1;
          STROBE: if (cnt == '0) st <= WAITCK;
                  else cnt <= cnt - 1'b1;
          WAITCK: if (!wait_on) begin
            if (!second) narrow <= io & wide & ~is16_s;
            if (!wr) begin
              if (second)                rd_q[15:8] <= card_din[7:0];
              else if (io & wide & ~is16_s) rd_q[7:0] <= card_din[7:0];
              else if (io & ~wide)       rd_q <= {8'h00, card_din[7:0]};
              else                       rd_q <= card_din;
            end
            cnt <= lim(hold_clks);
            st  <= HOLD;
          end
          HOLD: if (cnt == '0) begin
            if (io & wide & narrow & ~second) begin
              second    <= 1'b1;
              addr_q[0] <= 1'b1;
              cnt       <= lim(setup_clks);
              st        <= SETUP;
            end else begin
              done_q <= 1'b1;
              st     <= IDLE;
            end
          end else cnt <= cnt - 1'b1;
          default: st <= IDLE;
        endcase
      end
    end
  end

  wire any_strobe = ~(oe_n & we_n & iord_n & iowr_n);

  // R1
  common_no_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && k == 2'd0) |-> reg_n);

  // R6
  io_strobe_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!iord_n || !iowr_n) |-> !reg_n);

  // R4
  wait_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAITCK && wait_on && !reset_cmd) |=> any_strobe);

  // R11
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_reset |-> (!any_strobe && !req_ready));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R13
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !second && $past(!second)) |-> $stable(card_addr));

  // R5
  mem_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_kind[1]) |-> rdy_s);

endmodule

// File: tb/pc16_cycle_seq_test.sv
`timescale 1ns/1ps
module pc16_cycle_seq_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [3:0]  setup_clks = 4'd1, strobe_clks = 4'd2, hold_clks = 4'd1;
  logic [7:0]  reset_clks = 8'd3;
  logic        reset_cmd = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0, req_last = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] req_addr = '0, req_wdata = '0, card_din = '0;
  logic        wait_n = 1'b1, ready = 1'b1, wp_dreq = 1'b0, iois16_n = 1'b1;
  logic        req_ready, rsp_done, card_reset, card_dout_en;
  logic        oe_n, we_n, iord_n, iowr_n, reg_n;
  logic [15:0] rsp_rdata, card_addr, card_dout;

  pc16_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .setup_clks(setup_clks), .strobe_clks(strobe_clks),
    .hold_clks(hold_clks), .reset_clks(reset_clks), .reset_cmd(reset_cmd),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_write(req_write), .req_wide(req_wide), .req_last(req_last),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .card_reset(card_reset), .card_addr(card_addr),
    .card_dout(card_dout), .card_dout_en(card_dout_en), .card_din(card_din),
    .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n), .reg_n(reg_n),
    .wait_n(wait_n), .ready(ready), .wp_dreq(wp_dreq), .iois16_n(iois16_n));

  int vectors = 0, miscompares = 0;

  task automatic chk(input string tag, input string nm, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: got %h expected %h", tag, nm, $time, got, exp);
    end
  endtask

  // behavioural reference model
  bit          m_busy, m_sec, m_narrow, m_done, m_wr, m_wide, m_last, m_resetting;
  logic [1:0]  m_kind;
  logic [15:0] m_addr, m_wd, m_rd;
  int          m_el, m_ext, m_rst;
  logic [3:0]  m_s1 = 4'b1011, m_s2 = 4'b1011;
  bit          armed = 1'b0;

  function automatic int atleast1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function bit m_go(input logic [1:0] kd);
    if (kd == 2'd3) return m_s2[2];
    if (kd == 2'd2) return 1'b1;
    return m_s2[1];
  endfunction

  always @(posedge clk) begin
    armed <= 1'b1;
    if (!rst_n) begin
      m_busy = 0; m_sec = 0; m_narrow = 0; m_done = 0; m_wr = 0; m_wide = 0; m_last = 0;
      m_kind = 0; m_addr = 0; m_wd = 0; m_rd = 0; m_el = 0; m_ext = 0; m_rst = 0;
      m_s1 = 4'b1011; m_s2 = 4'b1011;
    end else begin
      m_resetting = (m_rst != 0);
      m_done = 0;
      if (m_rst != 0) m_rst = m_rst - 1;
      if (reset_cmd) begin
        m_busy = 0; m_sec = 0; m_rst = atleast1(int'(reset_clks));
      end else if (!m_busy) begin
        if (req_valid && !m_resetting && m_go(req_kind)) begin
          m_kind = req_kind; m_wr = req_write; m_wide = req_wide; m_last = req_last;
          m_wd = req_wdata; m_sec = 0; m_busy = 1; m_el = 0; m_ext = 0;
          m_addr = (req_kind == 2'd2 && req_wide) ? {req_addr[15:1], 1'b0} : req_addr;
        end
      end else begin
        if (m_el == atleast1(int'(setup_clks)) + atleast1(int'(strobe_clks)) + m_ext) begin
          if (!m_s2[0]) m_ext++;
          else begin
            if (!m_sec) m_narrow = (m_kind == 2'd2 && m_wide && m_s2[3]);
            if (!m_wr) begin
              if (m_sec) m_rd[15:8] = card_din[7:0];
              else if (m_kind == 2'd2 && m_wide && m_s2[3]) m_rd[7:0] = card_din[7:0];
              else if (m_kind == 2'd2 && !m_wide) m_rd = {8'h00, card_din[7:0]};
              else m_rd = card_din;
            end
          end
        end
        m_el++;
        if (m_el == atleast1(int'(setup_clks)) + atleast1(int'(strobe_clks)) + 1 + m_ext
                    + atleast1(int'(hold_clks))) begin
          if (m_kind == 2'd2 && m_wide && m_narrow && !m_sec) begin
            m_sec = 1; m_addr[0] = 1'b1; m_el = 0; m_ext = 0;
          end else begin
            m_busy = 0; m_done = 1;
          end
        end
      end
      m_s2 = m_s1;
      m_s1 = {iois16_n, wp_dreq, ready, wait_n};
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    #2;
    if (armed) begin
      bit act, mem, dma, io;
      act = m_busy && m_el >= atleast1(int'(setup_clks)) &&
            m_el < atleast1(int'(setup_clks)) + atleast1(int'(strobe_clks)) + 1 + m_ext;
      mem = (m_kind < 2'd2); io = (m_kind == 2'd2); dma = (m_kind == 2'd3);
      chk("R1",  "reg_n",  reg_n,  !(m_busy && m_kind != 2'd0));
      chk("R2",  "oe_n",   oe_n,   !(act && ((mem && !m_wr) || (dma && !m_wr && m_last))));
      chk("R7",  "we_n",   we_n,   !(act && ((mem && m_wr) || (dma && m_wr && m_last))));
      chk("R6",  "iord_n", iord_n, !(act && (io || dma) && !m_wr));
      chk("R6",  "iowr_n", iowr_n, !(act && (io || dma) && m_wr));
      chk("R3",  "rsp_done", rsp_done, m_done);
      chk("R10", "rsp_rdata", rsp_rdata, m_rd);
      chk("R11", "card_reset", card_reset, m_rst != 0);
      chk("R9",  "card_addr", card_addr, m_addr);
      chk("R13", "card_dout_en", card_dout_en, m_busy && m_wr);
      if (m_busy && m_wr) chk("R13", "card_dout", card_dout, m_sec ? {8'h00, m_wd[15:8]} : m_wd);
      chk("R5",  "req_ready", req_ready, !m_busy && m_rst == 0 && m_go(req_kind));
    end
  end

  int slen = 0;
  always @(negedge clk) begin
    #2;
    if (!iord_n) slen++;
  end

  task automatic access(input logic [1:0] kd, input logic w, input logic wd, input logic ls,
                        input logic [15:0] a, input logic [15:0] dat, input logic [15:0] din);
    @(negedge clk);
    req_kind = kd; req_write = w; req_wide = wd; req_last = ls;
    req_addr = a; req_wdata = dat; card_din = din; req_valid = 1'b1;
    #3;
    while (!req_ready) begin @(negedge clk); #3; end
    @(negedge clk);
    req_valid = 1'b0;
    #3;
    while (!rsp_done) begin @(negedge clk); #3; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired at %0t: got hung expected finish", $time);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int len0, len1;
    repeat (3) @(negedge clk);
    #3;
    chk("R11", "reset state card_reset", card_reset, 1'b0);
    chk("R1",  "reset state reg_n", reg_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2: common and attribute memory, read and write
    access(2'd0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0000, 16'hBEEF);
    chk("R10", "common read data", rsp_rdata, 16'hBEEF);
    access(2'd0, 1'b1, 1'b0, 1'b0, 16'h0042, 16'hC0DE, 16'h0000);
    access(2'd1, 1'b0, 1'b0, 1'b0, 16'h0200, 16'h0000, 16'h5A5A);
    access(2'd1, 1'b1, 1'b0, 1'b0, 16'h0201, 16'h00FF, 16'h0000);

    // R3: zero counts act as one; strobe of an I/O read is T+1 clocks
    @(negedge clk);
    setup_clks = 4'd0; strobe_clks = 4'd0; hold_clks = 4'd0;
    iois16_n = 1'b0;
    repeat (3) @(negedge clk);
    slen = 0;
    access(2'd2, 1'b0, 1'b1, 1'b0, 16'h03F8, 16'h0000, 16'hA1B2);
    len0 = slen;
    chk("R3", "strobe length with zero counts", len0, 2);
    chk("R10", "wide io read data", rsp_rdata, 16'hA1B2);

    // R4: wait held low stretches the strobe
    @(negedge clk);
    setup_clks = 4'd2; strobe_clks = 4'd2; hold_clks = 4'd3;
    wait_n = 1'b0;
    slen = 0;
    fork
      access(2'd2, 1'b0, 1'b0, 1'b0, 16'h0061, 16'h0000, 16'h77C3);
      begin repeat (9) @(negedge clk); wait_n = 1'b1; end
    join
    len1 = slen;
    chk("R4", "strobe stretched by wait", len1 > 3, 1'b1);
    chk("R10", "byte io read data", rsp_rdata, 16'h00C3);

    // R6: I/O write
    access(2'd2, 1'b1, 1'b0, 1'b0, 16'h0378, 16'h0055, 16'h0000);

    // R9: 16-bit I/O split into two byte cycles, read then write
    @(negedge clk);
    iois16_n = 1'b1;
    repeat (3) @(negedge clk);
    fork
      access(2'd2, 1'b0, 1'b1, 1'b0, 16'h0171, 16'h0000, 16'h0011);
      begin
        @(negedge clk);
        while (card_addr[0] !== 1'b1) @(negedge clk);
        card_din = 16'h0022;
      end
    join
    chk("R9", "split read assembly", rsp_rdata, 16'h2211);
    access(2'd2, 1'b1, 1'b1, 1'b0, 16'h0170, 16'hABCD, 16'h0000);

    // R12 R5: ready low blocks memory; release seen two clocks later
    @(negedge clk);
    ready = 1'b0; req_kind = 2'd0;
    repeat (4) @(negedge clk);
    #3;
    chk("R5", "memory blocked while not ready", req_ready, 1'b0);
    @(negedge clk);
    ready = 1'b1;
    @(negedge clk); #3;
    chk("R12", "ready after one clock", req_ready, 1'b0);
    @(negedge clk); #3;
    chk("R12", "ready after two clocks", req_ready, 1'b1);

    // R8 R7: DMA waits for request, then both directions with terminal count
    @(negedge clk);
    wp_dreq = 1'b0; req_kind = 2'd3;
    repeat (4) @(negedge clk);
    #3;
    chk("R8", "dma blocked without request", req_ready, 1'b0);
    fork
      access(2'd3, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h1357, 16'h0000);
      begin repeat (2) @(negedge clk); wp_dreq = 1'b1; end
    join
    access(2'd3, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h2468, 16'h0000);
    access(2'd3, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h9ABC);
    access(2'd3, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'hDEF0);
    chk("R7", "dma read data", rsp_rdata, 16'hDEF0);

    // R11: reset pulse aborts an access in progress
    @(negedge clk);
    strobe_clks = 4'd9; reset_clks = 8'd5;
    req_kind = 2'd2; req_write = 1'b0; req_wide = 1'b0; req_addr = 16'h0010; req_valid = 1'b1;
    #3;
    while (!req_ready) begin @(negedge clk); #3; end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    reset_cmd = 1'b1;
    @(negedge clk);
    reset_cmd = 1'b0;
    req_kind = 2'd2; req_valid = 1'b1;
    #3;
    len1 = 0;
    while (card_reset) begin
      len1++;
      @(negedge clk); #3;
      if (card_reset) chk("R11", "no request during reset", req_ready, 1'b0);
    end
    req_valid = 1'b0;
    chk("R11", "reset pulse length", len1, 5);
    repeat (12) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule